// File: doc/BRIEF.md
# PS/2 Mouse Command Responder

This block plays the device side of a PS/2 pointing device at byte level. A controller hands it one byte at a time with a valid strobe. The block answers with a stream of response bytes, one per clock and each marked by a push strobe, that feeds an auxiliary output queue. It holds three configuration values: a status byte, a resolution and a sample rate. Commands change these values, and a status request reads them back. Movement packets and the two-wire serial line are not part of this block.

A mode input selects how an incoming byte is handled. In send mode the byte is decoded as a device command, or as the argument of the command before it. In loopback mode the byte is pushed back unchanged and then acknowledged. While a response is being emitted, `busy` is high and incoming bytes are dropped.

The sequencer has these states:
- `ST_IDLE` waits for a byte.
- `ST_CMD_ACK` acknowledges a command and applies its register effect.
- `ST_DUMP_STAT`, `ST_DUMP_RES` and `ST_DUMP_RATE` emit the three-byte dump.
- `ST_SEND_ID` emits the identity byte.
- `ST_ARG_WAIT` waits for an argument byte.
- `ST_ECHO` returns a loopback byte.
- `ST_TAIL_ACK` emits the closing acknowledge after an argument or an echo.

The transitions are:
- IDLE→ECHO when a byte arrives in loopback mode.
- IDLE→CMD_ACK when a byte arrives in send mode.
- CMD_ACK→DUMP_STAT on 0xE9, CMD_ACK→SEND_ID on 0xF2, and CMD_ACK→ARG_WAIT on 0xE8 or 0xF3.
- CMD_ACK→IDLE for every other byte.
- DUMP_STAT→DUMP_RES→DUMP_RATE→IDLE.
- SEND_ID→IDLE.
- ARG_WAIT→TAIL_ACK when a byte arrives.
- ECHO→TAIL_ACK.
- TAIL_ACK→IDLE.

Top module: `ps2_mouse_responder`

## Requirements
- R1: A byte accepted in send mode outside an argument wait is answered in the next cycle by the acknowledge byte 0xFA, before any other byte.
- R2: Command 0xE9 yields 0xFA, then the status byte, then the resolution, then the sample rate, on four consecutive cycles.
- R3: Command 0xF2 yields 0xFA followed by the identity byte 0x00.
- R4: Command 0xF4 sets status bit 5 (reporting enabled). Command 0xF5 clears it. Each of them answers only 0xFA.
- R5: Command 0xE6 clears status bit 4 (scaling 1:1) and answers only 0xFA.
- R6: After reset, and after command 0xF6 or 0xFF, the status is 0x00, the resolution is 2 and the sample rate is 100 (0x64). Each of these commands answers only 0xFA.
- R7: In loopback mode an accepted byte is pushed back unchanged, and 0xFA follows in the next cycle.
- R8: After 0xE8 or 0xF3 the next accepted byte, in either mode, is stored as the new resolution or sample rate respectively, and is answered only with 0xFA.
- R9: Any other command byte is answered only with 0xFA and changes no register.
- R10: While `busy` is high, `in_valid` is ignored: the byte is neither answered nor acted on.
- R11: `out_push` is high on every cycle that `busy` is high and on no other cycle, so a response leaves as one unbroken burst. `busy` is low while waiting for an argument.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe from the controller |
| in_byte | input | 8 | Byte from the controller |
| loop_mode | input | 1 | 1 = loopback, 0 = send to device |
| out_push | output | 1 | Response byte valid, push into the queue |
| out_byte | output | 8 | Response byte |
| busy | output | 1 | A response is being emitted, input ignored |

## Verification
A wrong register value stays hidden until the next 0xE9 dump. The dump shows it in the second, third or fourth byte after the command, so the bench issues the status request often among the random traffic. A wrong state shows on the very next cycle: a missing or doubled 0xFA, a byte stream of the wrong length, or a `busy` that does not fall together with the last push. A byte that leaks through while `busy` is high shows either as an extra burst or as a status bit changing in a later dump.

// File: rtl/ps2m_pkg.sv
package ps2m_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CODE_SCALE_1TO1 = 8'hE6;
    localparam logic [BYTE_W-1:0] CODE_SET_RES    = 8'hE8;
    localparam logic [BYTE_W-1:0] CODE_STATUS_REQ = 8'hE9;
    localparam logic [BYTE_W-1:0] CODE_READ_ID    = 8'hF2;
    localparam logic [BYTE_W-1:0] CODE_SET_RATE   = 8'hF3;
    localparam logic [BYTE_W-1:0] CODE_REPORT_ON  = 8'hF4;
    localparam logic [BYTE_W-1:0] CODE_REPORT_OFF = 8'hF5;
    localparam logic [BYTE_W-1:0] CODE_DEFAULTS   = 8'hF6;
    localparam logic [BYTE_W-1:0] CODE_RESET      = 8'hFF;
    localparam logic [BYTE_W-1:0] BYTE_ACK        = 8'hFA;
    localparam logic [BYTE_W-1:0] BYTE_DEV_ID     = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD_ACK,
        ST_TAIL_ACK,
        ST_ARG_WAIT,
        ST_DUMP_STAT,
        ST_DUMP_RES,
        ST_DUMP_RATE,
        ST_SEND_ID,
        ST_ECHO
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_REPORT_ON,
        OP_REPORT_OFF,
        OP_SCALE_1TO1,
        OP_DEFAULTS,
        OP_WR_RES,
        OP_WR_RATE
    } reg_op_t;

endpackage

// File: rtl/ps2m_regs.sv
module ps2m_regs
    import ps2m_pkg::*;
#(
    parameter int                DATA_W     = BYTE_W,
    parameter logic [DATA_W-1:0] DEF_RES    = 8'd2,
    parameter logic [DATA_W-1:0] DEF_RATE   = 8'd100,
    parameter int                REPORT_BIT = 5,
    parameter int                SCALE_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_op_t           op,
    input  logic [DATA_W-1:0] arg,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] res,
    output logic [DATA_W-1:0] rate
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            res    <= DEF_RES;
            rate   <= DEF_RATE;
        end else begin
            unique case (op)
                OP_REPORT_ON:  status[REPORT_BIT] <= 1'b1;
                OP_REPORT_OFF: status[REPORT_BIT] <= 1'b0;
                OP_SCALE_1TO1: status[SCALE_BIT]  <= 1'b0;
                OP_DEFAULTS: begin
                    status <= '0;
                    res    <= DEF_RES;
                    rate   <= DEF_RATE;
                end
                OP_WR_RES:  res  <= arg;
                OP_WR_RATE: rate <= arg;
                default: ;
            endcase
        end
    end

    a_r4_report_on: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_REPORT_ON |=> status[REPORT_BIT]);

    a_r4_report_off: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_REPORT_OFF |=> !status[REPORT_BIT]);

    a_r6_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_DEFAULTS |=> (status == '0 && res == DEF_RES && rate == DEF_RATE));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_NONE |=> ($stable(status) && $stable(res) && $stable(rate)));

endmodule

// File: rtl/ps2m_seq.sv
module ps2m_seq
    import ps2m_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              loop_mode,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] rate,
    output reg_op_t           op,
    output logic [DATA_W-1:0] arg,
    output logic              out_push,
    output logic [DATA_W-1:0] out_byte,
    output logic              busy
);

    seq_state_t        state_q, state_d;
    logic [DATA_W-1:0] cmd_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (in_valid) state_d = loop_mode ? ST_ECHO : ST_CMD_ACK;
            ST_CMD_ACK: begin
                if (cmd_q == CODE_STATUS_REQ)
                    state_d = ST_DUMP_STAT;
                else if (cmd_q == CODE_READ_ID)
                    state_d = ST_SEND_ID;
                else if (cmd_q == CODE_SET_RES || cmd_q == CODE_SET_RATE)
                    state_d = ST_ARG_WAIT;
                else
                    state_d = ST_IDLE;
            end
            ST_ARG_WAIT:
                if (in_valid) state_d = ST_TAIL_ACK;
            ST_DUMP_STAT: state_d = ST_DUMP_RES;
            ST_DUMP_RES:  state_d = ST_DUMP_RATE;
            ST_DUMP_RATE: state_d = ST_IDLE;
            ST_SEND_ID:   state_d = ST_IDLE;
            ST_ECHO:      state_d = ST_TAIL_ACK;
            ST_TAIL_ACK:  state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register and captured command byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && in_valid) cmd_q <= in_byte;
        end
    end

    // Outputs and register operations
    always_comb begin
        out_push = 1'b1;
        out_byte = BYTE_ACK;
        op       = OP_NONE;
        arg      = in_byte;
        unique case (state_q)
            ST_IDLE: out_push = 1'b0;
            ST_ARG_WAIT: begin
                out_push = 1'b0;
                if (in_valid)
                    op = (cmd_q == CODE_SET_RES) ? OP_WR_RES : OP_WR_RATE;
            end
            ST_CMD_ACK: begin
                if (cmd_q == CODE_REPORT_ON)
                    op = OP_REPORT_ON;
                else if (cmd_q == CODE_REPORT_OFF)
                    op = OP_REPORT_OFF;
                else if (cmd_q == CODE_SCALE_1TO1)
                    op = OP_SCALE_1TO1;
                else if (cmd_q == CODE_DEFAULTS || cmd_q == CODE_RESET)
                    op = OP_DEFAULTS;
            end
            ST_TAIL_ACK:  out_byte = BYTE_ACK;
            ST_DUMP_STAT: out_byte = status;
            ST_DUMP_RES:  out_byte = res;
            ST_DUMP_RATE: out_byte = rate;
            ST_SEND_ID:   out_byte = BYTE_DEV_ID;
            ST_ECHO:      out_byte = cmd_q;
            default:      out_push = 1'b0;
        endcase
    end

    assign busy = (state_q != ST_IDLE) && (state_q != ST_ARG_WAIT);

    a_r1_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && state_q == ST_IDLE && in_valid && !loop_mode)
        |=> (out_push && out_byte == BYTE_ACK));

    a_r7_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && in_valid && loop_mode)
        |=> (out_push && out_byte == $past(in_byte)));

    a_r7_echo_ack: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ECHO |=> (out_push && out_byte == BYTE_ACK));

    a_r2_dump_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD_ACK && cmd_q == CODE_STATUS_REQ)
        |=> (out_push && out_byte == status));

    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q));

    a_r11_push_burst: assert property (@(posedge clk) disable iff (!rst_n)
        out_push == busy);

endmodule

// File: rtl/ps2_mouse_responder.sv
module ps2_mouse_responder
    import ps2m_pkg::*;
#(
    parameter int                DATA_W     = BYTE_W,
    parameter logic [DATA_W-1:0] DEF_RES    = 8'd2,
    parameter logic [DATA_W-1:0] DEF_RATE   = 8'd100,
    parameter int                REPORT_BIT = 5,
    parameter int                SCALE_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              loop_mode,
    output logic              out_push,
    output logic [DATA_W-1:0] out_byte,
    output logic              busy
);

    reg_op_t           op;
    logic [DATA_W-1:0] arg;
    logic [DATA_W-1:0] status, res, rate;

    ps2m_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .loop_mode(loop_mode),
        .status   (status),
        .res      (res),
        .rate     (rate),
        .op       (op),
        .arg      (arg),
        .out_push (out_push),
        .out_byte (out_byte),
        .busy     (busy)
    );

    ps2m_regs #(
        .DATA_W    (DATA_W),
        .DEF_RES   (DEF_RES),
        .DEF_RATE  (DEF_RATE),
        .REPORT_BIT(REPORT_BIT),
        .SCALE_BIT (SCALE_BIT)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .arg   (arg),
        .status(status),
        .res   (res),
        .rate  (rate)
    );

endmodule

// File: tb/tb_ps2_mouse_responder.sv
module tb_ps2_mouse_responder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       loop_mode = 1'b0;
    logic       out_push;
    logic [7:0] out_byte;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [7:0] m_status = 8'h00;
    logic [7:0] m_res    = 8'd2;
    logic [7:0] m_rate   = 8'd100;
    int         m_pend   = 0;

    logic [7:0] got [0:7];
    logic [7:0] exp_b [0:7];
    int n_got, n_exp, n_cyc;
    logic push_after;

    always #4 clk = ~clk;

    ps2_mouse_responder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .loop_mode(loop_mode), .out_push(out_push), .out_byte(out_byte), .busy(busy)
    );

    // Build the expected response and update the model
    task automatic model(input logic [7:0] b, input bit lp, output string tag);
        n_exp = 0;
        if (m_pend != 0) begin
            exp_b[n_exp++] = 8'hFA;
            if (m_pend == 1) m_res = b; else m_rate = b;
            m_pend = 0;
            tag = "R8";
        end else if (lp) begin
            exp_b[n_exp++] = b;
            exp_b[n_exp++] = 8'hFA;
            tag = "R7";
        end else begin
            exp_b[n_exp++] = 8'hFA;
            tag = "R1/R9";
            case (b)
                8'hE9: begin
                    exp_b[n_exp++] = m_status;
                    exp_b[n_exp++] = m_res;
                    exp_b[n_exp++] = m_rate;
                    tag = "R2";
                end
                8'hF2: begin exp_b[n_exp++] = 8'h00; tag = "R3"; end
                8'hF4: begin m_status[5] = 1'b1; tag = "R4"; end
                8'hF5: begin m_status[5] = 1'b0; tag = "R4"; end
                8'hE6: begin m_status[4] = 1'b0; tag = "R5"; end
                8'hF6, 8'hFF: begin
                    m_status = 8'h00; m_res = 8'd2; m_rate = 8'd100; tag = "R6";
                end
                8'hE8: begin m_pend = 1; tag = "R8"; end
                8'hF3: begin m_pend = 2; tag = "R8"; end
                default: ;
            endcase
        end
    endtask

    // Collect pushed bytes while busy; intr cycles of ignored input are injected
    task automatic collect(input int intr);
        n_got = 0;
        n_cyc = 0;
        while (busy && n_cyc < 8) begin
            if (out_push && n_got < 8) got[n_got++] = out_byte;
            n_cyc++;
            if (n_cyc <= intr) begin
                in_valid = 1'b1; in_byte = 8'hF4; loop_mode = 1'b0;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        push_after = out_push;
    endtask

    task automatic compare(input string tag);
        bit bad = (n_got != n_exp) || (n_cyc != n_got) || push_after;
        checks++;
        if (!bad)
            for (int i = 0; i < n_exp; i++) if (got[i] !== exp_b[i]) bad = 1'b1;
        if (bad) begin
            errors++;
            $display("FAIL %s: got %0d bytes (%0d busy cycles, push_after=%0b) %h %h %h %h, expected %0d bytes %h %h %h %h",
                tag, n_got, n_cyc, push_after, got[0], got[1], got[2], got[3],
                n_exp, exp_b[0], exp_b[1], exp_b[2], exp_b[3]);
        end
    endtask

    task automatic xfer(input logic [7:0] b, input bit lp, input int intr);
        string tag;
        model(b, lp, tag);
        for (int i = 0; i < 8; i++) got[i] = 8'hxx;
        in_valid = 1'b1; in_byte = b; loop_mode = lp;
        @(negedge clk);
        in_valid = 1'b0;
        collect(intr);
        if (intr > 0) tag = "R10";
        compare(tag);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reset state at the ports
        checks++;
        if (out_push !== 1'b0 || busy !== 1'b0) begin
            errors++;
            $display("FAIL R6: after reset push=%0b busy=%0b, expected 0 0", out_push, busy);
        end
        xfer(8'hE9, 0, 0);                 // R6 and R2: default dump
        xfer(8'hF2, 0, 0);                 // R3
        xfer(8'hF4, 0, 0);                 // R4
        xfer(8'hE9, 0, 0);
        xfer(8'hE8, 0, 0);                 // R8 resolution
        xfer(8'h03, 1, 0);                 // R8 argument in loopback mode
        xfer(8'hF3, 0, 0);
        xfer(8'd40, 0, 0);
        xfer(8'hE9, 0, 0);
        xfer(8'hF5, 0, 0);
        xfer(8'hE6, 0, 0);                 // R5
        xfer(8'h5A, 1, 0);                 // R7 loopback
        xfer(8'hE9, 1, 0);                 // R7 command code is echoed, not decoded
        xfer(8'h12, 0, 0);                 // R9 unknown command
        xfer(8'hE9, 0, 2);                 // R10 F4 offered while busy
        xfer(8'hE9, 0, 0);                 // R10 status bit 5 still clear
        xfer(8'hFF, 0, 0);                 // R6
        xfer(8'hE9, 0, 0);

        for (int t = 0; t < 400; t++) begin
            logic [7:0] b;
            int sel = $urandom % 11;
            bit lp = ($urandom % 5) == 0;
            case (sel)
                0: b = 8'hE6;  1: b = 8'hE8;  2: b = 8'hE9;  3: b = 8'hF2;
                4: b = 8'hF3;  5: b = 8'hF4;  6: b = 8'hF5;  7: b = 8'hF6;
                8: b = 8'hFF;  9: b = 8'hE9;
                default: b = 8'($urandom);
            endcase
            if (m_pend != 0) b = 8'($urandom);
            xfer(b, lp, (($urandom % 8) == 0) ? 1 : 0);
        end
        xfer(8'hE9, 0, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule